// File: doc/BRIEF.md
# Watchdog Timer with Routed Reset Requests

This block is a register-mapped watchdog. Software loads a reload value and enables the timer. The counter then counts down once on each microsecond tick. Software keeps the system alive by writing a fixed restart code, which reloads the counter. If the count reaches zero, the block expires.

On expiry, a configuration field routes the event to one of three mutually exclusive reset requests: CPU, SoC or full system. A fourth setting routes it to none of them, so that another watchdog on the chip can own the reset. An expiry can also latch an alternate-boot flag. It can also drive a pulse of programmable length on an external pin, either open-drain or push-pull, and the polarity can be chosen in push-pull mode.

Registers sit on a simple single-cycle bus with a write strobe, a 3-bit address and 32-bit data. Reads are combinational.

Address map:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | bit 0 run enable; bits [2:1] reset target; bit 3 alternate-boot enable; bit 4 external enable; bit 5 push-pull; bit 6 active-high |
| 1 | reload | read/write | reload value |
| 2 | restart | write only | restart code |
| 3 | status | read, write 1 to clear | bit 0 expiry flag |
| 4 | count | read only | live counter value |
| 5 | pulse length | read/write | external pulse length in ticks |

Top module: `wdt_rst_sel`

## Requirements
- R1: The reset target field is control bits [2:1], encoded 0 = CPU, 1 = SoC, 2 = system and 3 = none. On expiry, only the selected output among `rst_cpu_o`, `rst_soc_o` and `rst_sys_o` asserts, and at no time is more than one of them high.
- R2: With the target field set to 3 (none), an expiry asserts none of the three reset outputs.
- R3: After `rst_ni`, the control register reads 0x4: the target is system and every enable is clear. All outputs are low.
- R4: If control bit 3 is set, an expiry sets `alt_boot_o`. The flag then stays high until `rst_ni`.
- R5: While control bit 4 (external enable) is clear, `ext_oe_o` is never asserted, including at expiry.
- R6: On an expiry with the external output enabled, the pulse lasts exactly the number of ticks held in the pulse-length register (address 5).
- R7: Open-drain drive is selected when control bit 5 is clear. In this mode `ext_data_o` is always 0, and `ext_oe_o` is high only during the pulse.
- R8: Push-pull drive is selected when control bit 5 is set. In this mode `ext_oe_o` stays high while the external output is enabled. The pin idles at the inactive level and takes the active level during the pulse. The active level is high only if control bit 6 is set. Bit 6 has no effect in open-drain mode.
- R9: A write that raises control bit 0 loads the counter from the reload register (address 1). The counter decrements only on cycles where `tick_i` is high. The count reads at address 4. Expiry occurs on the first tick that finds the count at zero, so with `tick_i` held high it occurs reload+1 cycles after the enabling write.
- R10: Writing `RESTART_CODE` to address 2 reloads the counter. A write of any other value to address 2 leaves the count unchanged.
- R11: An expiry sets status bit 0 and clears control bit 0, so the counter stops. Writing 0 to status leaves the bit set. Writing 1 to status clears it.
- R12: The reset outputs are driven from registers. They rise on the clock edge that follows the expiring tick cycle and stay high for exactly `RST_HOLD` (16) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Microsecond tick enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| rst_cpu_o | output | 1 | CPU reset request |
| rst_soc_o | output | 1 | SoC reset request |
| rst_sys_o | output | 1 | System reset request |
| alt_boot_o | output | 1 | Boot-from-alternate-image flag |
| ext_data_o | output | 1 | External pin data |
| ext_oe_o | output | 1 | External pin output enable |

## Verification
The bench builds the block with a 16-bit counter, an 8-bit pulse-length field, the 16-cycle reset hold and the default restart code. It keeps `tick_i` high most of the time. This makes each expiry, each reset window and each pulse width land at an exact number of clock cycles that the bench can count. The tick is held low on purpose at one point, to show that the count freezes between ticks and that a wrong restart value has no effect. The small reload values used let all four target settings and all three pin modes be exercised in a few hundred cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    RST_CPU  = 2'd0,
    RST_SOC  = 2'd1,
    RST_SYS  = 2'd2,
    RST_NONE = 2'd3
  } rst_sel_e;

  typedef struct packed {
    logic     act_high;
    logic     push_pull;
    logic     ext_en;
    logic     alt_en;
    rst_sel_e sel;
    logic     en;
  } ctrl_t;

  localparam logic [2:0] A_CTRL    = 3'd0;
  localparam logic [2:0] A_RELOAD  = 3'd1;
  localparam logic [2:0] A_RESTART = 3'd2;
  localparam logic [2:0] A_STATUS  = 3'd3;
  localparam logic [2:0] A_COUNT   = 3'd4;
  localparam logic [2:0] A_PLEN    = 3'd5;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int          CNT_W        = 32,
  parameter int          PW_W         = 8,
  parameter logic [31:0] RESTART_CODE = 32'h5A5A_A5A5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [PW_W-1:0]  plen_o,
  output logic             load_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [PW_W-1:0]  plen_q;
  logic             sts_q;
  logic             start_wr, restart_wr;

  assign start_wr   = we_i && addr_i == A_CTRL && wdata_i[0] && !ctrl_q.en;
  assign restart_wr = we_i && addr_i == A_RESTART && wdata_i == RESTART_CODE;
  assign load_o     = start_wr || restart_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '{sel: RST_SYS, default: '0};
      reload_q <= '0;
      plen_q   <= '0;
      sts_q    <= 1'b0;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_CTRL:   ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
          A_RELOAD: reload_q <= wdata_i[CNT_W-1:0];
          A_PLEN:   plen_q   <= wdata_i[PW_W-1:0];
          A_STATUS: if (wdata_i[0]) sts_q <= 1'b0;
          default: ;
        endcase
      end
      // expiry wins over a same-cycle software write
      if (expire_i) begin
        ctrl_q.en <= 1'b0;
        sts_q     <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:   rdata_o = 32'(ctrl_q);
      A_RELOAD: rdata_o = 32'(reload_q);
      A_STATUS: rdata_o = 32'(sts_q);
      A_COUNT:  rdata_o = 32'(cnt_i);
      A_PLEN:   rdata_o = 32'(plen_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign plen_o   = plen_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (load_i)                            cnt_q <= reload_i;
    else if (run_i && tick_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = run_i && tick_i && cnt_q == '0 && !load_i;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdt_rst_route.sv
module wdt_rst_route import wdt_pkg::*; #(
  parameter int RST_HOLD = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     expire_i,
  input  rst_sel_e sel_i,
  input  logic     alt_en_i,
  output logic     rst_cpu_o,
  output logic     rst_soc_o,
  output logic     rst_sys_o,
  output logic     alt_boot_o
);
  localparam int HW = $clog2(RST_HOLD + 1);

  logic [HW-1:0] hold_q;
  rst_sel_e      sel_q;
  logic          alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sel_q  <= RST_NONE;
      alt_q  <= 1'b0;
    end else begin
      if (expire_i) begin
        sel_q  <= sel_i;
        hold_q <= (sel_i == RST_NONE) ? '0 : HW'(RST_HOLD);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - HW'(1);
      end
      if (expire_i && alt_en_i) alt_q <= 1'b1;
    end
  end

  assign rst_cpu_o  = hold_q != '0 && sel_q == RST_CPU;
  assign rst_soc_o  = hold_q != '0 && sel_q == RST_SOC;
  assign rst_sys_o  = hold_q != '0 && sel_q == RST_SYS;
  assign alt_boot_o = alt_q;
endmodule

// File: rtl/wdt_ext_pulse.sv
module wdt_ext_pulse #(
  parameter int PW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            expire_i,
  input  logic            ext_en_i,
  input  logic            push_pull_i,
  input  logic            act_high_i,
  input  logic [PW_W-1:0] len_i,
  output logic            data_o,
  output logic            oe_o
);
  logic [PW_W-1:0] pcnt_q;
  logic            active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pcnt_q <= '0;
    else if (expire_i && ext_en_i)        pcnt_q <= len_i;
    else if (tick_i && pcnt_q != '0)      pcnt_q <= pcnt_q - PW_W'(1);
  end

  assign active = pcnt_q != '0;

  always_comb begin
    if (!ext_en_i) begin
      oe_o   = 1'b0;
      data_o = 1'b0;
    end else if (push_pull_i) begin
      oe_o   = 1'b1;
      data_o = act_high_i ? active : !active;
    end else begin
      // open-drain: only ever pull low
      oe_o   = active;
      data_o = 1'b0;
    end
  end
endmodule

// File: rtl/wdt_rst_sel.sv
module wdt_rst_sel import wdt_pkg::*; #(
  parameter int          CNT_W        = 32,
  parameter int          PW_W         = 8,
  parameter int          RST_HOLD     = 16,
  parameter logic [31:0] RESTART_CODE = 32'h5A5A_A5A5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rst_cpu_o,
  output logic        rst_soc_o,
  output logic        rst_sys_o,
  output logic        alt_boot_o,
  output logic        ext_data_o,
  output logic        ext_oe_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload, cnt;
  logic [PW_W-1:0]  plen;
  logic             load, expire;

  wdt_regs #(.CNT_W(CNT_W), .PW_W(PW_W), .RESTART_CODE(RESTART_CODE)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .expire_i(expire), .cnt_i(cnt), .ctrl_o(ctrl_q),
    .reload_o(reload), .plen_o(plen), .load_o(load)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .run_i(ctrl_q.en), .load_i(load),
    .reload_i(reload), .cnt_o(cnt), .expire_o(expire)
  );

  wdt_rst_route #(.RST_HOLD(RST_HOLD)) u_route (
    .clk_i, .rst_ni, .expire_i(expire), .sel_i(ctrl_q.sel), .alt_en_i(ctrl_q.alt_en),
    .rst_cpu_o, .rst_soc_o, .rst_sys_o, .alt_boot_o
  );

  wdt_ext_pulse #(.PW_W(PW_W)) u_ext (
    .clk_i, .rst_ni, .tick_i, .expire_i(expire), .ext_en_i(ctrl_q.ext_en),
    .push_pull_i(ctrl_q.push_pull), .act_high_i(ctrl_q.act_high), .len_i(plen),
    .data_o(ext_data_o), .oe_o(ext_oe_o)
  );
endmodule

// File: rtl/wdt_rst_sel_chk.sv
module wdt_rst_sel_chk import wdt_pkg::*; (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     expire_i,
  input rst_sel_e sel_i,
  input logic     ext_en_i,
  input logic     push_pull_i,
  input logic     rst_cpu_o,
  input logic     rst_soc_o,
  input logic     rst_sys_o,
  input logic     alt_boot_o,
  input logic     ext_data_o,
  input logic     ext_oe_o
);
  AST_RST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_cpu_o, rst_soc_o, rst_sys_o})); // R1
  AST_NONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && sel_i == RST_NONE) |=> !(rst_cpu_o || rst_soc_o || rst_sys_o)); // R2
  AST_ALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_boot_o |=> alt_boot_o); // R4
  AST_EXT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |-> !ext_oe_o); // R5
  AST_OD_LOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_en_i && !push_pull_i) |-> !ext_data_o); // R7
  AST_STOP_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> !expire_i); // R11
  AST_SYS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && sel_i == RST_SYS) |=> rst_sys_o); // R12
endmodule

bind wdt_rst_sel wdt_rst_sel_chk u_chk (
  .clk_i, .rst_ni, .expire_i(expire), .sel_i(ctrl_q.sel),
  .ext_en_i(ctrl_q.ext_en), .push_pull_i(ctrl_q.push_pull),
  .rst_cpu_o, .rst_soc_o, .rst_sys_o, .alt_boot_o, .ext_data_o, .ext_oe_o
);

// File: tb/wdt_rst_sel_tb_top.sv
module wdt_rst_sel_tb_top;
  localparam logic [31:0] CODE = 32'h5A5A_A5A5;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rst_cpu, rst_soc, rst_sys, alt_boot, ext_data, ext_oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wdt_rst_sel #(.CNT_W(16), .PW_W(8), .RST_HOLD(HOLD), .RESTART_CODE(CODE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_cpu_o(rst_cpu), .rst_soc_o(rst_soc),
    .rst_sys_o(rst_sys), .alt_boot_o(alt_boot), .ext_data_o(ext_data), .ext_oe_o(ext_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic wait_expire(output int n);
    logic [31:0] s;
    n = 0;
    do begin @(negedge clk); n++; rd(3'd3, s); end while (!s[0] && n < 500);
  endtask

  task automatic clear_idle();
    repeat (HOLD + 4) @(negedge clk);
    wr(3'd3, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d);
    chk(d == 32'h4, "R3 ctrl reset", int'(d), 4);
    chk({rst_cpu, rst_soc, rst_sys, alt_boot, ext_oe} == 5'b0, "R3 outputs idle",
        int'({rst_cpu, rst_soc, rst_sys, alt_boot, ext_oe}), 0);
  endtask

  task automatic t_sys_timeout();
    int n, h;
    logic [31:0] d;
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h5);
    wait_expire(n);
    chk(n == 6, "R9 expiry latency", n, 6);
    chk({rst_cpu, rst_soc, rst_sys} == 3'b001, "R1 system only", int'({rst_cpu, rst_soc, rst_sys}), 1);
    chk(!ext_oe, "R5 pin undriven", int'(ext_oe), 0);
    chk(!alt_boot, "R4 alt clear", int'(alt_boot), 0);
    h = 0;
    while (rst_sys && h < 100) begin h++; @(negedge clk); end
    chk(h == HOLD, "R12 hold length", h, HOLD);
    rd(3'd0, d);
    chk(d[0] == 1'b0, "R11 enable cleared", int'(d[0]), 0);
    wr(3'd3, 32'd0);
    rd(3'd3, d);
    chk(d[0] == 1'b1, "R11 write 0 keeps", int'(d[0]), 1);
    wr(3'd3, 32'd1);
    rd(3'd3, d);
    chk(d[0] == 1'b0, "R11 write 1 clears", int'(d[0]), 0);
  endtask

  task automatic t_target(input logic [1:0] sel, input logic [2:0] exp);
    int n;
    wr(3'd1, 32'd3);
    wr(3'd0, 32'(1 | (sel << 1)));
    wait_expire(n);
    chk({rst_cpu, rst_soc, rst_sys} == exp, "R1 target select", int'({rst_cpu, rst_soc, rst_sys}), int'(exp));
    clear_idle();
  endtask

  task automatic t_none();
    int n, seen;
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h7);
    wait_expire(n);
    chk(n == 4, "R9 expiry latency none", n, 4);
    seen = 0;
    repeat (HOLD + 4) begin
      if (rst_cpu || rst_soc || rst_sys) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R2 none silent", seen, 0);
    wr(3'd3, 32'd1);
  endtask

  task automatic t_restart();
    int n;
    logic [31:0] d;
    tick = 1'b0;
    wr(3'd1, 32'd10);
    wr(3'd0, 32'h5);
    repeat (5) @(negedge clk);
    rd(3'd4, d);
    chk(d == 32'd10, "R9 frozen without tick", int'(d), 10);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    rd(3'd4, d);
    chk(d == 32'd7, "R9 three ticks", int'(d), 7);
    wr(3'd2, CODE ^ 32'h1);
    rd(3'd4, d);
    chk(d == 32'd7, "R10 bad code ignored", int'(d), 7);
    wr(3'd2, CODE);
    rd(3'd4, d);
    chk(d == 32'd10, "R10 restart reloads", int'(d), 10);
    tick = 1'b1;
    wait_expire(n);
    chk(n == 11, "R10 latency after restart", n, 11);
    clear_idle();
  endtask

  task automatic t_alt();
    int n;
    wr(3'd1, 32'd2);
    wr(3'd0, 32'd13);
    wait_expire(n);
    chk(alt_boot, "R4 alt set", int'(alt_boot), 1);
    clear_idle();
    chk(alt_boot, "R4 alt sticky", int'(alt_boot), 1);
  endtask

  // ctrl value, expected idle oe/data, expected active oe/data
  task automatic t_ext(input logic [31:0] c, input logic ioe, input logic idat,
                       input logic aoe, input logic adat, input string req);
    int n, w;
    wr(3'd5, 32'd5);
    wr(3'd1, 32'd4);
    wr(3'd0, c);
    chk(ext_oe == ioe && ext_data == idat, {req, " idle"}, int'({ext_oe, ext_data}), int'({ioe, idat}));
    wait_expire(n);
    chk(ext_oe == aoe && ext_data == adat, {req, " active"}, int'({ext_oe, ext_data}), int'({aoe, adat}));
    w = 0;
    while (ext_oe == aoe && ext_data == adat && w < 100) begin w++; @(negedge clk); end
    chk(w == 5, "R6 pulse length", w, 5);
    chk(ext_oe == ioe && ext_data == idat, {req, " after"}, int'({ext_oe, ext_data}), int'({ioe, idat}));
    clear_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sys_timeout();
    t_target(2'd0, 3'b100);
    t_target(2'd1, 3'b010);
    t_none();
    t_restart();
    t_alt();
    t_ext(32'd21,  1'b0, 1'b0, 1'b1, 1'b0, "R7 open-drain");
    t_ext(32'd53,  1'b1, 1'b1, 1'b1, 1'b0, "R8 push-pull low");
    t_ext(32'd117, 1'b1, 1'b0, 1'b1, 1'b1, "R8 push-pull high");
    t_ext(32'd85,  1'b0, 1'b0, 1'b1, 1'b0, "R8 polarity ignored open-drain");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule